// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block takes one power-gated domain down or up through a fixed, ordered series of control steps. A single request strobe carries a direction. From that the sequencer drives the domain's control lines one at a time: bus protection, SRAM isolation and retention, logic isolation, clock gating, reset, and a two-stage power switch. Between steps it waits for the acknowledges that come back from the switch cells, the SRAM macro and the bus protection logic. Four capability straps are latched when a request is accepted. They select whether the domain has SRAM at all, whether the SRAM retains through a sleep control or is powered down, whether SRAM isolation cells exist, and whether an extra retention delay is needed before reset release.

All delays are counted in ticks of a 1 µs strobe. Each acknowledge wait has a bound of `POLL_LIMIT * POLL_GAP_US` ticks. If the bound expires, the sequence aborts: the control lines keep their current values, the machine returns to idle, and `err` stays high until the next request is accepted. A successful sequence ends with a one-cycle `done` pulse.

The states are as follows.

- Idle: `S_IDLE`. Any request starts a sequence.
- Power-down: `S_D_PROT_ON`, `S_D_PROT_WAIT`, `S_D_SCKISO_ON`, `S_D_SISO_OFF`, `S_D_SISO_WAIT`, `S_D_SRAM_OFF`, `S_D_SRAM_WAIT`, `S_D_ISO_ON`, `S_D_CLK_OFF`, `S_D_RST_ON`, `S_D_MAIN_OFF`, `S_D_MAIN_WAIT`, `S_D_AUX_OFF`, `S_D_AUX_WAIT`.
- Power-up: `S_U_MAIN_ON`, `S_U_MAIN_WAIT`, `S_U_SETTLE`, `S_U_AUX_ON`, `S_U_AUX_WAIT`, `S_U_CLK_ON`, `S_U_ISO_OFF`, `S_U_RET_WAIT`, `S_U_RST_OFF`, `S_U_SRAM_ON`, `S_U_SRAM_WAIT`, `S_U_SISO_ON`, `S_U_SISO_WAIT`, `S_U_SCKISO_OFF`, `S_U_PROT_OFF`.
- Completion: both paths end in `S_DONE`, which returns to `S_IDLE`.

The transitions are as follows.

- Skip rules: the SRAM states are skipped when the domain has no SRAM. The SRAM isolation states are skipped without isolation cells. `S_U_RET_WAIT` is skipped without the retention strap.
- Timeout: every `*_WAIT` state on an acknowledge goes to `S_IDLE` with the error set when its bound expires.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the domain reads as off: `dom_rst_n`=0, `dom_iso`=1, `sw_main`=0, `sw_aux`=0, `clk_off`=1, `sram_ckiso`=1, `sram_iso_n`=0, `sram_pd`=1, `sram_slp`=0, `prot_req`=1, and `busy`, `done` and `err` are 0.
- R2: A request is accepted only while `busy` is 0. A request that arrives while a sequence runs has no effect on the outputs or on the sequence, and no output changes while idle.
- R3: Power-down drives the lines in this order:
  - `prot_req` high, then a wait for `prot_ack`;
  - the SRAM-off phase;
  - `dom_iso` high, then `clk_off` high, then `dom_rst_n` low;
  - `sw_main` low and a wait for `ack_main` low;
  - `sw_aux` low and a wait for `ack_aux` low.
- R4: Power-up drives the lines in this order:
  - `sw_main` high and a wait for `ack_main`;
  - a settle of `SETTLE_US` ticks, then `sw_aux` high and a wait for `ack_aux`;
  - `clk_off` low, then `dom_iso` low, then `dom_rst_n` high.
- R5: When `cap_ret_delay` is set, at least `RET_US` ticks pass between `dom_iso` falling and `dom_rst_n` rising. Otherwise they change on consecutive cycles.
- R6: The SRAM mode depends on `cap_sram_sleep`. With it 0, off sets `sram_pd` and waits for `ack_sram_pd`=1, and on clears it and waits for 0. With it 1, off clears `sram_slp` and waits for `ack_sram_slp`=0, and on sets it and waits for 1.
- R7: With `cap_sram_iso` set, SRAM-off first sets `sram_ckiso`, then clears `sram_iso_n` and waits `SRAM_ISO_US` ticks. SRAM-on, after its acknowledge, sets `sram_iso_n`, waits `SRAM_ISO_US` ticks and then clears `sram_ckiso`.
- R8: With `cap_no_sram` set, no SRAM line changes in either direction.
- R9: An acknowledge wait that exceeds `POLL_LIMIT*POLL_GAP_US` ticks ends the sequence. `err` rises, `done` stays low, all control lines hold, and the block returns to idle. `err` clears when the next request is accepted.
- R10: A completed sequence raises `done` for exactly one cycle, after which `busy` is 0.
- R11: At most one control line (including `prot_req`) changes in any clock cycle.
- R12: `prot_req` is the first line raised on power-down and the last line lowered on power-up, and the release does not wait on `prot_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| req | input | 1 | Start strobe, sampled while idle |
| req_up | input | 1 | Direction of the request: 1 power up, 0 power down |
| cap_no_sram | input | 1 | Strap: domain has no SRAM |
| cap_sram_sleep | input | 1 | Strap: SRAM uses sleep control instead of power-down |
| cap_sram_iso | input | 1 | Strap: SRAM isolation cells present |
| cap_ret_delay | input | 1 | Strap: extra retention delay before reset release |
| prot_ack | input | 1 | Bus protection engaged |
| ack_main | input | 1 | Primary switch acknowledge |
| ack_aux | input | 1 | Secondary switch acknowledge |
| ack_sram_pd | input | 1 | SRAM power-down acknowledge |
| ack_sram_slp | input | 1 | SRAM sleep acknowledge |
| prot_req | output | 1 | Request bus protection |
| dom_rst_n | output | 1 | Domain reset, active low |
| dom_iso | output | 1 | Domain output isolation |
| sw_main | output | 1 | Primary power switch enable |
| sw_aux | output | 1 | Secondary power switch enable |
| clk_off | output | 1 | Domain clock disable |
| sram_ckiso | output | 1 | SRAM clock isolation |
| sram_iso_n | output | 1 | SRAM isolation, active low |
| sram_pd | output | 1 | SRAM power-down |
| sram_slp | output | 1 | SRAM sleep control |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Last sequence aborted on an acknowledge timeout |

## Verification
The bench builds the block with `POLL_LIMIT`=3, `POLL_GAP_US`=2, `SETTLE_US`=5, `RET_US`=4 and `SRAM_ISO_US`=2, with the microsecond strobe on every second cycle. These values bring the timeout abort within about twelve cycles of a frozen acknowledge, and let the settle, retention and SRAM isolation delays be measured as cycle gaps between output changes. With these values every strap combination, the timeout path and a request during a busy sequence all fit in a few hundred cycles.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int NUM_LINES = 10;
    localparam int SEL_W     = 4;

    // Index of each control line inside the line register.
    typedef enum logic [SEL_W-1:0] {
        L_RST_N  = 4'd0,
        L_ISO    = 4'd1,
        L_MAIN   = 4'd2,
        L_AUX    = 4'd3,
        L_CLKOFF = 4'd4,
        L_SCKISO = 4'd5,
        L_SISO_N = 4'd6,
        L_SPD    = 4'd7,
        L_SSLP   = 4'd8,
        L_PROT   = 4'd9
    } line_e;

    // Domain-off values: protected, isolated, clock stopped, in reset, SRAM down.
    localparam logic [NUM_LINES-1:0] LINES_OFF = 10'b10_1011_0010;

    typedef enum logic [4:0] {
        S_IDLE,
        S_D_PROT_ON, S_D_PROT_WAIT, S_D_SCKISO_ON, S_D_SISO_OFF, S_D_SISO_WAIT,
        S_D_SRAM_OFF, S_D_SRAM_WAIT, S_D_ISO_ON, S_D_CLK_OFF, S_D_RST_ON,
        S_D_MAIN_OFF, S_D_MAIN_WAIT, S_D_AUX_OFF, S_D_AUX_WAIT,
        S_U_MAIN_ON, S_U_MAIN_WAIT, S_U_SETTLE, S_U_AUX_ON, S_U_AUX_WAIT,
        S_U_CLK_ON, S_U_ISO_OFF, S_U_RET_WAIT, S_U_RST_OFF, S_U_SRAM_ON,
        S_U_SRAM_WAIT, S_U_SISO_ON, S_U_SISO_WAIT, S_U_SCKISO_OFF, S_U_PROT_OFF,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/pds_tick_timer.sv
module pds_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (tick && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pds_line_reg.sv
module pds_line_reg #(
    parameter int                   NL      = 10,
    parameter int                   SW      = 4,
    parameter logic [NL-1:0]        RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [SW-1:0] sel,
    input  logic          val,
    output logic [NL-1:0] lines
);
    for (genvar i = 0; i < NL; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lines[i] <= RST_VAL[i];
            end else if (wr && (sel == SW'(i))) begin
                lines[i] <= val;
            end
        end
    end
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TIMEOUT_TK  = 6,
    parameter int SETTLE_US   = 50,
    parameter int RET_US      = 10,
    parameter int SRAM_ISO_US = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_up,
    input  logic             cap_no_sram,
    input  logic             cap_sram_sleep,
    input  logic             cap_sram_iso,
    input  logic             cap_ret_delay,
    input  logic             prot_ack,
    input  logic             ack_main,
    input  logic             ack_aux,
    input  logic             ack_sram_pd,
    input  logic             ack_sram_slp,
    input  logic [CNT_W-1:0] count,
    output logic             restart,
    output logic             wr,
    output line_e            sel,
    output logic             val,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam logic [CNT_W-1:0] TO_LIM  = CNT_W'(TIMEOUT_TK);
    localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(SETTLE_US);
    localparam logic [CNT_W-1:0] RET_LIM = CNT_W'(RET_US);
    localparam logic [CNT_W-1:0] ISO_LIM = CNT_W'(SRAM_ISO_US);

    seq_state_e state_q, state_d;
    logic       nos_q, slp_q, siso_q, ret_q;
    logic       accept, fail, expired;
    logic       sram_off_ok, sram_on_ok;

    assign accept      = (state_q == S_IDLE) && req;
    assign expired     = (count >= TO_LIM);
    assign sram_off_ok = slp_q ? !ack_sram_slp : ack_sram_pd;
    assign sram_on_ok  = slp_q ? ack_sram_slp : !ack_sram_pd;
    assign restart     = (state_d != state_q);

    // State register, latched straps and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            nos_q   <= 1'b0;
            slp_q   <= 1'b0;
            siso_q  <= 1'b0;
            ret_q   <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                nos_q  <= cap_no_sram;
                slp_q  <= cap_sram_sleep;
                siso_q <= cap_sram_iso;
                ret_q  <= cap_ret_delay;
                err    <= 1'b0;
            end else if (fail) begin
                err <= 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        fail    = 1'b0;
        unique case (state_q)
            S_IDLE:
                if (req) state_d = req_up ? S_U_MAIN_ON : S_D_PROT_ON;
            // ---- power-down ----
            S_D_PROT_ON:   state_d = S_D_PROT_WAIT;
            S_D_PROT_WAIT:
                if (prot_ack) begin
                    if (nos_q)       state_d = S_D_ISO_ON;
                    else if (siso_q) state_d = S_D_SCKISO_ON;
                    else             state_d = S_D_SRAM_OFF;
                end else if (expired) begin
                    fail = 1'b1; state_d = S_IDLE;
                end
            S_D_SCKISO_ON: state_d = S_D_SISO_OFF;
            S_D_SISO_OFF:  state_d = S_D_SISO_WAIT;
            S_D_SISO_WAIT:
                if (count >= ISO_LIM) state_d = S_D_SRAM_OFF;
            S_D_SRAM_OFF:  state_d = S_D_SRAM_WAIT;
            S_D_SRAM_WAIT:
                if (sram_off_ok) state_d = S_D_ISO_ON;
                else if (expired) begin
                    fail = 1'b1; state_d = S_IDLE;
                end
            S_D_ISO_ON:    state_d = S_D_CLK_OFF;
            S_D_CLK_OFF:   state_d = S_D_RST_ON;
            S_D_RST_ON:    state_d = S_D_MAIN_OFF;
            S_D_MAIN_OFF:  state_d = S_D_MAIN_WAIT;
            S_D_MAIN_WAIT:
                if (!ack_main) state_d = S_D_AUX_OFF;
                else if (expired) begin
                    fail = 1'b1; state_d = S_IDLE;
                end
            S_D_AUX_OFF:   state_d = S_D_AUX_WAIT;
            S_D_AUX_WAIT:
                if (!ack_aux) state_d = S_DONE;
                else if (expired) begin
                    fail = 1'b1; state_d = S_IDLE;
                end
            // ---- power-up ----
            S_U_MAIN_ON:   state_d = S_U_MAIN_WAIT;
            S_U_MAIN_WAIT:
                if (ack_main) state_d = S_U_SETTLE;
                else if (expired) begin
                    fail = 1'b1; state_d = S_IDLE;
                end
            S_U_SETTLE:
                if (count >= SET_LIM) state_d = S_U_AUX_ON;
            S_U_AUX_ON:    state_d = S_U_AUX_WAIT;
            S_U_AUX_WAIT:
                if (ack_aux) state_d = S_U_CLK_ON;
                else if (expired) begin
                    fail = 1'b1; state_d = S_IDLE;
                end
            S_U_CLK_ON:    state_d = S_U_ISO_OFF;
            S_U_ISO_OFF:   state_d = ret_q ? S_U_RET_WAIT : S_U_RST_OFF;
            S_U_RET_WAIT:
                if (count >= RET_LIM) state_d = S_U_RST_OFF;
            S_U_RST_OFF:   state_d = nos_q ? S_U_PROT_OFF : S_U_SRAM_ON;
            S_U_SRAM_ON:   state_d = S_U_SRAM_WAIT;
            S_U_SRAM_WAIT:
                if (sram_on_ok) state_d = siso_q ? S_U_SISO_ON : S_U_PROT_OFF;
                else if (expired) begin
                    fail = 1'b1; state_d = S_IDLE;
                end
            S_U_SISO_ON:   state_d = S_U_SISO_WAIT;
            S_U_SISO_WAIT:
                if (count >= ISO_LIM) state_d = S_U_SCKISO_OFF;
            S_U_SCKISO_OFF: state_d = S_U_PROT_OFF;
            S_U_PROT_OFF:  state_d = S_DONE;
            S_DONE:        state_d = S_IDLE;
            default:       state_d = S_IDLE;
        endcase
    end

    // Outputs: one line write per command state
    always_comb begin
        wr   = 1'b0;
        sel  = L_RST_N;
        val  = 1'b0;
        busy = (state_q != S_IDLE);
        done = (state_q == S_DONE);
        unique case (state_q)
            S_D_PROT_ON:    begin wr = 1'b1; sel = L_PROT;   val = 1'b1; end
            S_D_SCKISO_ON:  begin wr = 1'b1; sel = L_SCKISO; val = 1'b1; end
            S_D_SISO_OFF:   begin wr = 1'b1; sel = L_SISO_N; val = 1'b0; end
            S_D_SRAM_OFF:   begin
                wr  = 1'b1;
                sel = slp_q ? L_SSLP : L_SPD;
                val = !slp_q;
            end
            S_D_ISO_ON:     begin wr = 1'b1; sel = L_ISO;    val = 1'b1; end
            S_D_CLK_OFF:    begin wr = 1'b1; sel = L_CLKOFF; val = 1'b1; end
            S_D_RST_ON:     begin wr = 1'b1; sel = L_RST_N;  val = 1'b0; end
            S_D_MAIN_OFF:   begin wr = 1'b1; sel = L_MAIN;   val = 1'b0; end
            S_D_AUX_OFF:    begin wr = 1'b1; sel = L_AUX;    val = 1'b0; end
            S_U_MAIN_ON:    begin wr = 1'b1; sel = L_MAIN;   val = 1'b1; end
            S_U_AUX_ON:     begin wr = 1'b1; sel = L_AUX;    val = 1'b1; end
            S_U_CLK_ON:     begin wr = 1'b1; sel = L_CLKOFF; val = 1'b0; end
            S_U_ISO_OFF:    begin wr = 1'b1; sel = L_ISO;    val = 1'b0; end
            S_U_RST_OFF:    begin wr = 1'b1; sel = L_RST_N;  val = 1'b1; end
            S_U_SRAM_ON:    begin
                wr  = 1'b1;
                sel = slp_q ? L_SSLP : L_SPD;
                val = slp_q;
            end
            S_U_SISO_ON:    begin wr = 1'b1; sel = L_SISO_N; val = 1'b1; end
            S_U_SCKISO_OFF: begin wr = 1'b1; sel = L_SCKISO; val = 1'b0; end
            S_U_PROT_OFF:   begin wr = 1'b1; sel = L_PROT;   val = 1'b0; end
            default:        ;
        endcase
    end
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
    import pds_pkg::*;
#(
    parameter int POLL_LIMIT  = 10000,
    parameter int POLL_GAP_US = 10,
    parameter int SETTLE_US   = 50,
    parameter int RET_US      = 10,
    parameter int SRAM_ISO_US = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic req,
    input  logic req_up,
    input  logic cap_no_sram,
    input  logic cap_sram_sleep,
    input  logic cap_sram_iso,
    input  logic cap_ret_delay,
    input  logic prot_ack,
    input  logic ack_main,
    input  logic ack_aux,
    input  logic ack_sram_pd,
    input  logic ack_sram_slp,
    output logic prot_req,
    output logic dom_rst_n,
    output logic dom_iso,
    output logic sw_main,
    output logic sw_aux,
    output logic clk_off,
    output logic sram_ckiso,
    output logic sram_iso_n,
    output logic sram_pd,
    output logic sram_slp,
    output logic busy,
    output logic done,
    output logic err
);
    localparam int TIMEOUT_TK = POLL_LIMIT * POLL_GAP_US;
    localparam int MAX_A      = (TIMEOUT_TK > SETTLE_US) ? TIMEOUT_TK : SETTLE_US;
    localparam int MAX_B      = (RET_US > SRAM_ISO_US) ? RET_US : SRAM_ISO_US;
    localparam int MAX_TK     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W      = $clog2(MAX_TK + 2);

    logic [CNT_W-1:0]     count;
    logic                 restart;
    logic                 wr;
    line_e                sel;
    logic [SEL_W-1:0]     sel_bits;
    logic                 val;
    logic [NUM_LINES-1:0] lines;

    assign sel_bits = sel;

    pds_fsm #(
        .CNT_W      (CNT_W),
        .TIMEOUT_TK (TIMEOUT_TK),
        .SETTLE_US  (SETTLE_US),
        .RET_US     (RET_US),
        .SRAM_ISO_US(SRAM_ISO_US)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .req_up        (req_up),
        .cap_no_sram   (cap_no_sram),
        .cap_sram_sleep(cap_sram_sleep),
        .cap_sram_iso  (cap_sram_iso),
        .cap_ret_delay (cap_ret_delay),
        .prot_ack      (prot_ack),
        .ack_main      (ack_main),
        .ack_aux       (ack_aux),
        .ack_sram_pd   (ack_sram_pd),
        .ack_sram_slp  (ack_sram_slp),
        .count         (count),
        .restart       (restart),
        .wr            (wr),
        .sel           (sel),
        .val           (val),
        .busy          (busy),
        .done          (done),
        .err           (err)
    );

    pds_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .tick   (tick_us),
        .count  (count)
    );

    pds_line_reg #(
        .NL     (NUM_LINES),
        .SW     (SEL_W),
        .RST_VAL(LINES_OFF)
    ) u_lines (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (wr),
        .sel  (sel_bits),
        .val  (val),
        .lines(lines)
    );

    assign dom_rst_n  = lines[L_RST_N];
    assign dom_iso    = lines[L_ISO];
    assign sw_main    = lines[L_MAIN];
    assign sw_aux     = lines[L_AUX];
    assign clk_off    = lines[L_CLKOFF];
    assign sram_ckiso = lines[L_SCKISO];
    assign sram_iso_n = lines[L_SISO_N];
    assign sram_pd    = lines[L_SPD];
    assign sram_slp   = lines[L_SSLP];
    assign prot_req   = lines[L_PROT];
endmodule

// File: rtl/pds_checker.sv
module pds_checker (
    input logic clk,
    input logic rst_n,
    input logic ack_main,
    input logic prot_req,
    input logic dom_rst_n,
    input logic dom_iso,
    input logic sw_main,
    input logic sw_aux,
    input logic clk_off,
    input logic sram_ckiso,
    input logic sram_iso_n,
    input logic sram_pd,
    input logic sram_slp,
    input logic busy,
    input logic done,
    input logic err
);
    logic [9:0] ctl;
    assign ctl = {prot_req, sram_slp, sram_pd, sram_iso_n, sram_ckiso,
                  clk_off, sw_aux, sw_main, dom_iso, dom_rst_n};

    AST_ONE_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctl ^ $past(ctl)) <= 1);                                   // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(ctl));                                              // R2
    AST_CLK_OFF_AFTER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_off) |-> dom_iso);                                          // R3
    AST_MAIN_OFF_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_main) |-> (!dom_rst_n && dom_iso && clk_off));               // R3
    AST_AUX_AFTER_MAIN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_aux) |-> (sw_main && ack_main));                             // R4
    AST_RST_RELEASE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_rst_n) |-> (!dom_iso && !clk_off && sw_aux));               // R4
    AST_SRAM_CKISO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_iso_n) |-> sram_ckiso);                                    // R7
    AST_PROT_RELEASE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_req) |-> (dom_rst_n && !dom_iso));                         // R12
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                      // R10
    AST_DONE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err);                                                       // R9
endmodule

bind pwr_domain_seq pds_checker u_pds_checker (.*);

// File: tb/pwr_domain_seq_test.sv
`timescale 1ns/1ps
module pwr_domain_seq_test;
    localparam int P_POLL = 3;
    localparam int P_GAP  = 2;
    localparam int P_SET  = 5;
    localparam int P_RET  = 4;
    localparam int P_ISO  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b0;
    logic req = 1'b0, req_up = 1'b0;
    logic cap_no_sram = 1'b0, cap_sram_sleep = 1'b0, cap_sram_iso = 1'b0, cap_ret_delay = 1'b0;
    logic prot_ack = 1'b0, ack_main = 1'b0, ack_aux = 1'b0, ack_sram_pd = 1'b1, ack_sram_slp = 1'b0;
    logic prot_req, dom_rst_n, dom_iso, sw_main, sw_aux, clk_off;
    logic sram_ckiso, sram_iso_n, sram_pd, sram_slp, busy, done, err;

    pwr_domain_seq #(
        .POLL_LIMIT(P_POLL), .POLL_GAP_US(P_GAP), .SETTLE_US(P_SET),
        .RET_US(P_RET), .SRAM_ISO_US(P_ISO)
    ) uut (.*);

    always #2 clk = ~clk;

    // Responders: each acknowledge follows its control line two cycles later.
    logic d_prot = 1'b1, d_main = 1'b0, d_aux = 1'b0, d_pd = 1'b1, d_slp = 1'b0;
    logic freeze_main = 1'b0;
    int   cyc = 0;
    always @(posedge clk) begin
        cyc      <= cyc + 1;
        tick_us  <= ~tick_us;
        d_prot   <= prot_req;  prot_ack     <= d_prot;
        d_main   <= sw_main;   if (!freeze_main) ack_main <= d_main;
        d_aux    <= sw_aux;    ack_aux      <= d_aux;
        d_pd     <= sram_pd;   ack_sram_pd  <= d_pd;
        d_slp    <= sram_slp;  ack_sram_slp <= d_slp;
    end

    // Line vector in bench order: 0 rst_n, 1 iso, 2 main, 3 aux, 4 clk_off,
    // 5 sram_ckiso, 6 sram_iso_n, 7 sram_pd, 8 sram_slp, 9 prot_req.
    logic [9:0] dv;
    assign dv = {prot_req, sram_slp, sram_pd, sram_iso_n, sram_ckiso,
                 clk_off, sw_aux, sw_main, dom_iso, dom_rst_n};
    localparam logic [9:0] OFF_V = 10'b1010110010;

    int    total = 0, failed = 0;
    int    exp_q[$];
    int    ev_t[20];
    bit    [9:0] model = OFF_V;
    bit    [9:0] prev  = OFF_V;
    string cur_req = "R1";

    task automatic check(input bit ok, input string r, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, expv);
        end
    endtask

    task automatic want(input int f, input bit v);
        if (model[f] != v) begin
            model[f] = v;
            exp_q.push_back(f * 2 + int'(v));
        end
    endtask

    task automatic plan_down(input bit nos, input bit slp, input bit iso);
        want(9, 1'b1);
        if (!nos) begin
            if (iso) begin want(5, 1'b1); want(6, 1'b0); end
            if (slp) want(8, 1'b0); else want(7, 1'b1);
        end
        want(1, 1'b1); want(4, 1'b1); want(0, 1'b0); want(2, 1'b0); want(3, 1'b0);
    endtask

    task automatic plan_up(input bit nos, input bit slp, input bit iso);
        want(2, 1'b1); want(3, 1'b1); want(4, 1'b0); want(1, 1'b0); want(0, 1'b1);
        if (!nos) begin
            if (slp) want(8, 1'b1); else want(7, 1'b0);
            if (iso) begin want(6, 1'b1); want(5, 1'b0); end
        end
        want(9, 1'b0);
    endtask

    // Monitor: pops one expected change per observed line change.
    always @(negedge clk) begin
        if (rst_n && (dv != prev)) begin
            check($countones(dv ^ prev) == 1, "R11", "lines changed in one cycle",
                  $countones(dv ^ prev), 1);
            for (int j = 0; j < 10; j++) begin
                int code;
                int e;
                code = j * 2 + int'(dv[j]);
                if (dv[j] != prev[j]) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, cur_req, "unexpected line change", code, -1);
                    end else begin
                        e = exp_q.pop_front();
                        check(e == code, cur_req, "line change order", code, e);
                    end
                    ev_t[code] = cyc;
                end
            end
            prev = dv;
        end
    end

    task automatic run(input bit up, input bit nos, input bit slp, input bit iso,
                       input bit ret, input bit ok_exp, input string r);
        int  n;
        bit  saw_done;
        bit  saw_err;
        cur_req = r;
        cap_no_sram = nos; cap_sram_sleep = slp; cap_sram_iso = iso; cap_ret_delay = ret;
        req_up = up;
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        n = 0; saw_done = 1'b0; saw_err = 1'b0;
        while (!saw_done && !saw_err && n < 3000) begin
            @(negedge clk);
            n++;
            if (done) saw_done = 1'b1;
            if (err)  saw_err  = 1'b1;
        end
        if (ok_exp) begin
            check(saw_done && !err, "R10", "sequence completes", int'(saw_done), 1);
            @(negedge clk);
            check(!done && !busy, "R10", "done lasts one cycle", int'(done | busy), 0);
        end else begin
            check(saw_err && !saw_done, "R9", "timeout raises err", int'(saw_err), 1);
        end
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, r, "pending expected changes", exp_q.size(), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dv == OFF_V, "R1", "line values after reset", int'(dv), int'(OFF_V));
        check(!busy && !done && !err, "R1", "status after reset",
              int'({busy, done, err}), 0);

        // Power up: SRAM in power-down mode, isolation cells, no retention delay
        plan_up(1'b0, 1'b0, 1'b1);
        run(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        check(ev_t[7] - ev_t[5] >= 2 * P_SET - 1, "R4", "settle gap main to aux",
              ev_t[7] - ev_t[5], 2 * P_SET - 1);
        check(ev_t[1] - ev_t[2] == 1, "R5", "no retention delay gap",
              ev_t[1] - ev_t[2], 1);
        check(ev_t[10] - ev_t[13] >= 2 * P_ISO - 1, "R7", "SRAM iso gap on power-up",
              ev_t[10] - ev_t[13], 2 * P_ISO - 1);
        check(prot_req == 1'b0, "R12", "protection released", int'(prot_req), 0);

        // Power down, same straps
        plan_down(1'b0, 1'b0, 1'b1);
        run(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        check(ev_t[15] - ev_t[12] >= 2 * P_ISO - 1, "R7", "SRAM iso gap on power-down",
              ev_t[15] - ev_t[12], 2 * P_ISO - 1);
        check(prot_req == 1'b1, "R12", "protection engaged", int'(prot_req), 1);

        // Power up in sleep mode, no SRAM isolation, retention delay
        plan_up(1'b0, 1'b1, 1'b0);
        run(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
        check(ev_t[1] - ev_t[2] >= 2 * P_RET - 1, "R5", "retention delay gap",
              ev_t[1] - ev_t[2], 2 * P_RET - 1);
        check(sram_slp && sram_pd, "R6", "sleep set, power-down untouched",
              int'({sram_slp, sram_pd}), 3);

        // Power down in sleep mode
        plan_down(1'b0, 1'b1, 1'b0);
        run(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        check(!sram_slp, "R6", "sleep cleared", int'(sram_slp), 0);

        // No SRAM: both directions leave SRAM lines alone
        plan_up(1'b1, 1'b0, 1'b1);
        run(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
        check(dv[8:5] == 4'b0101, "R8", "SRAM lines after power-up", int'(dv[8:5]), 5);
        plan_down(1'b1, 1'b0, 1'b1);
        run(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R8");

        // Timeout on the primary acknowledge
        freeze_main = 1'b1;
        want(2, 1'b1);
        run(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        repeat (10) @(negedge clk);
        check(err && !busy, "R9", "err held, idle", int'({err, busy}), 2);
        check(sw_main && !sw_aux && prot_req, "R9", "lines hold after abort",
              int'({sw_main, sw_aux, prot_req}), 5);
        freeze_main = 1'b0;
        repeat (6) @(negedge clk);

        // Next request clears err
        plan_down(1'b1, 1'b0, 1'b0);
        cur_req = "R9";
        fork
            run(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
            begin
                repeat (3) @(negedge clk);
                check(!err, "R9", "err cleared on accept", int'(err), 0);
            end
        join

        // Request during a busy sequence is ignored
        plan_up(1'b1, 1'b0, 1'b0);
        fork
            run(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
            begin
                repeat (8) @(negedge clk);
                req_up = 1'b0; req = 1'b1;
                @(negedge clk);
                req = 1'b0;
            end
        join
        repeat (20) @(negedge clk);
        check(sw_main && sw_aux && !prot_req && !busy, "R2", "busy request ignored",
              int'({sw_main, sw_aux, prot_req, busy}), 12);
        check(exp_q.size() == 0, "R2", "no extra changes", exp_q.size(), 0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule